// File: doc/BRIEF.md
# Quadword SECDED Memory Protection Datapath

This block sits between a single-request host port and a 72-bit wide synchronous memory. Every stored 64-bit quadword carries 8 check bits that are computed here on the way in and verified here on the way out. The memory stores bits only.

The code is an extended Hamming (72,64) code: seven Hamming check bits plus one overall parity bit. A read with correction enabled repairs any single flipped bit, returns clean data and still reports the repair. Errors touching more than one bit are reported as uncorrectable. With correction disabled, the block reports both error classes and returns the stored data bits unchanged.

A write whose byte enables are not all set is turned into a read-modify-write. The block reads the stored word, checks it, merges in the enabled bytes, re-encodes the whole word and writes all 72 bits back. If the read finds an uncorrectable error, the write-back is dropped and the error is reported.

Top module: `ecc_qword_ctrl`

## Requirements
- R1: Every word written to memory carries the data in bits [63:0] and check bits in [71:64], and the XOR of all 72 stored bits is 0.
- R2: A read of an undisturbed word returns the written data with both error flags low and a zero syndrome.
- R3: With correction enabled, a single flipped stored bit at any of the 72 positions is repaired. The response then has the original data, the single flag high, the multi flag low, and syndrome[7]=1. Syndrome[6:0] is 2^j for check bit 64+j (j=0..6), 0 for bit 71, and for data bit i the (i+1)-th integer of 3 or more that is not a power of two.
- R4: Two flipped stored bits give multi=1 and single=0, whether correction is enabled or not.
- R5: With correction disabled, a single flipped bit gives single=1 and multi=0, and the response returns stored bits [63:0] uncorrected.
- R6: A write with byte enables not all ones replaces byte k (bits 8k+7:8k) only where enable bit k is 1. The old bytes are kept, the stored word is re-encoded per R1, and every write response returns zero data.
- R7: When the read phase of a partial write finds a single-bit error with correction enabled, the merge uses the corrected old data, the write is done, and the write response has single=1.
- R8: When the read phase of a partial write finds an uncorrectable error, memory is left unchanged and the write response has multi=1.
- R9: Only one request is in flight. req_ready_o is low from the accepting edge until the response is taken. The response and its data and flags hold steady while rsp_ready_i is low.
- R10: A full write's response is valid in the cycle after the accepting edge. A read's or partial write's response is valid one cycle later than that.
- R11: During and right after reset, rsp_valid_o and mem_en_o are low and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| corr_en_i | input | 1 | 1: correct single-bit errors; 0: detect only |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | ADDR_W | Quadword address |
| req_wdata_i | input | 64 | Write data |
| req_be_i | input | 8 | Byte enables for writes |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken when high with valid |
| rsp_rdata_o | output | 64 | Read data (zero for writes) |
| rsp_single_o | output | 1 | Single-bit error seen |
| rsp_multi_o | output | 1 | Uncorrectable error seen |
| rsp_syndrome_o | output | 8 | {overall parity, Hamming syndrome} |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write when high with strobe |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | 72 | Coded word to memory |
| mem_rdata_i | input | 72 | Coded word from memory, one cycle after a read strobe |

## Verification
The assertions take four things for granted. Memory returns the read word exactly one cycle after a read strobe. corr_en_i does not change while a request is in flight. req_valid_i stays low during reset. rsp_ready_i may be held low for any number of cycles. The bench meets these by driving inputs only on falling edges, changing the correction mode only while idle, and modelling memory as a one-cycle registered array. It flips stored bits only between transactions, through that array's own write process, and each response is held for one extra cycle before it is taken.

// File: rtl/ecc_qword_pkg.sv
package ecc_qword_pkg;
  localparam int DATA_W  = 64;
  localparam int HAM_W   = 7;
  localparam int CODE_W  = DATA_W + HAM_W + 1;
  localparam int BYTES   = DATA_W / 8;
  localparam int MAX_POS = DATA_W + HAM_W;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_RSP} state_t;

  // data bit n sits at the n-th non-power-of-two Hamming position >= 3
  function automatic logic [DATA_W-1:0] cover_mask(int j);
    logic [DATA_W-1:0] m;
    int n;
    m = '0;
    n = 0;
    for (int p = 3; p < (1 << HAM_W); p++) begin
      if ((p & (p - 1)) != 0 && n < DATA_W) begin
        m[n] = ((p >> j) & 1) != 0;
        n++;
      end
    end
    return m;
  endfunction

  function automatic logic [HAM_W-1:0] data_pos(int idx);
    logic [HAM_W-1:0] r;
    int n;
    r = '0;
    n = 0;
    for (int p = 3; p < (1 << HAM_W); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == idx) r = HAM_W'(p);
        n++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_qword_enc.sv
module ecc_qword_enc
  import ecc_qword_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  logic [HAM_W-1:0] ham;

  for (genvar j = 0; j < HAM_W; j++) begin : g_ham
    localparam logic [DATA_W-1:0] MASK = cover_mask(j);
    assign ham[j] = ^(data_i & MASK);
  end

  assign code_o = {^{ham, data_i}, ham, data_i};
endmodule

// File: rtl/ecc_qword_dec.sv
module ecc_qword_dec
  import ecc_qword_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              corr_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_o,
  output logic              multi_o,
  output logic [HAM_W:0]    syndrome_o
);
  localparam logic [HAM_W-1:0] LAST_POS = HAM_W'(MAX_POS);

  logic [CODE_W-1:0] recalc;
  logic [HAM_W-1:0]  syn;
  logic              par_odd;
  logic [DATA_W-1:0] flip;

  ecc_qword_enc u_enc (
    .data_i (code_i[DATA_W-1:0]),
    .code_o (recalc)
  );

  assign syn     = recalc[DATA_W +: HAM_W] ^ code_i[DATA_W +: HAM_W];
  assign par_odd = ^code_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam logic [HAM_W-1:0] POS = data_pos(i);
    assign flip[i] = (syn == POS);
  end

  // syndrome 0 with odd parity: overall parity bit itself flipped
  assign single_o   = par_odd && (syn <= LAST_POS);
  assign multi_o    = (!par_odd && syn != '0) || (par_odd && syn > LAST_POS);
  assign syndrome_o = {par_odd, syn};
  assign data_o     = code_i[DATA_W-1:0] ^ ((corr_en_i && single_o) ? flip : '0);
endmodule

// File: rtl/ecc_byte_merge.sv
module ecc_byte_merge
  import ecc_qword_pkg::*;
(
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [BYTES-1:0]  be_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    assign data_o[8*k +: 8] = be_i[k] ? new_i[8*k +: 8] : old_i[8*k +: 8];
  end
endmodule

// File: rtl/ecc_qword_ctrl.sv
module ecc_qword_ctrl
  import ecc_qword_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              corr_en_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [BYTES-1:0]  req_be_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_single_o,
  output logic              rsp_multi_o,
  output logic [HAM_W:0]    rsp_syndrome_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [CODE_W-1:0] mem_wdata_o,
  input  logic [CODE_W-1:0] mem_rdata_i
);
  state_t            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BYTES-1:0]  be_q;
  logic              write_q;

  logic              accept, full_write, in_rd;
  logic [DATA_W-1:0] dec_data, merged, enc_data;
  logic              dec_single, dec_multi;
  logic [HAM_W:0]    dec_syn;

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RSP);
  assign accept      = req_valid_i && req_ready_o;
  assign full_write  = req_write_i && (&req_be_i);
  assign in_rd       = (state_q == ST_RD);

  ecc_qword_dec u_dec (
    .code_i     (mem_rdata_i),
    .corr_en_i  (corr_en_i),
    .data_o     (dec_data),
    .single_o   (dec_single),
    .multi_o    (dec_multi),
    .syndrome_o (dec_syn)
  );

  ecc_byte_merge u_merge (
    .old_i  (dec_data),
    .new_i  (wdata_q),
    .be_i   (be_q),
    .data_o (merged)
  );

  assign enc_data = in_rd ? merged : req_wdata_i;

  ecc_qword_enc u_enc (
    .data_i (enc_data),
    .code_o (mem_wdata_o)
  );

  // read-modify-write commits only when the old word was usable
  assign mem_en_o   = accept || (in_rd && write_q && !dec_multi);
  assign mem_we_o   = mem_en_o && (in_rd || full_write);
  assign mem_addr_o = in_rd ? addr_q : req_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      addr_q         <= '0;
      wdata_q        <= '0;
      be_q           <= '0;
      write_q        <= 1'b0;
      rsp_rdata_o    <= '0;
      rsp_single_o   <= 1'b0;
      rsp_multi_o    <= 1'b0;
      rsp_syndrome_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          be_q    <= req_be_i;
          write_q <= req_write_i;
          if (full_write) begin
            rsp_rdata_o    <= '0;
            rsp_single_o   <= 1'b0;
            rsp_multi_o    <= 1'b0;
            rsp_syndrome_o <= '0;
            state_q        <= ST_RSP;
          end else begin
            state_q <= ST_RD;
          end
        end
        ST_RD: begin
          rsp_rdata_o    <= write_q ? '0 : dec_data;
          rsp_single_o   <= dec_single;
          rsp_multi_o    <= dec_multi;
          rsp_syndrome_o <= dec_syn;
          state_q        <= ST_RSP;
        end
        ST_RSP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecc_qword_ctrl_chk.sv
module ecc_qword_ctrl_chk
  import ecc_qword_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              rsp_single_o,
  input logic              rsp_multi_o,
  input logic [HAM_W:0]    rsp_syndrome_o,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  assert_rsp_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o)
      && $stable(rsp_single_o) && $stable(rsp_multi_o) && $stable(rsp_syndrome_o));

  assert_busy_not_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  assert_flags_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(rsp_single_o && rsp_multi_o));

  assert_single_has_syndrome_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_single_o |-> rsp_syndrome_o[HAM_W]);

  assert_no_writeback_on_multi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && mem_we_o |=> rsp_valid_o && !rsp_multi_o);

  assert_mem_access_order_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> (req_valid_i && req_ready_o) || $past(mem_en_o && !mem_we_o));

  assert_rmw_same_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && !(req_valid_i && req_ready_o) |-> mem_addr_o == $past(mem_addr_o));
endmodule

bind ecc_qword_ctrl ecc_qword_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_ready_i    (rsp_ready_i),
  .rsp_rdata_o    (rsp_rdata_o),
  .rsp_single_o   (rsp_single_o),
  .rsp_multi_o    (rsp_multi_o),
  .rsp_syndrome_o (rsp_syndrome_o),
  .mem_en_o       (mem_en_o),
  .mem_we_o       (mem_we_o),
  .mem_addr_o     (mem_addr_o)
);

// File: tb/ecc_qword_ctrl_tb_top.sv
module ecc_qword_ctrl_tb_top;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        corr_en = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_be = '0;
  logic        req_ready, rsp_valid, rsp_single, rsp_multi;
  logic [63:0] rsp_rdata;
  logic [7:0]  rsp_syn;
  logic        mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [71:0] mem_wdata, mem_rdata;

  logic [71:0] mem [1 << AW];
  logic        inj_en = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [71:0] inj_mask = '0;

  int checks = 0, errors = 0;
  logic [63:0] r_data;
  logic        r_single, r_multi;
  logic [7:0]  r_syn;
  int          r_lat;

  always #4 clk = ~clk;

  ecc_qword_ctrl #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .corr_en_i(corr_en),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .rsp_single_o(rsp_single), .rsp_multi_o(rsp_multi), .rsp_syndrome_o(rsp_syn),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  initial for (int i = 0; i < (1 << AW); i++) mem[i] = '0;

  always @(posedge clk) begin
    if (inj_en) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
    else if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(int k);
    return 64'h0123_4567_89AB_CDEF ^ (64'(k + 1) * 64'h9E37_79B9_7F4A_7C15);
  endfunction

  // expected Hamming position of stored bit k
  function automatic logic [6:0] exp_pos(int k);
    int n;
    logic [6:0] r;
    r = '0;
    n = 0;
    if (k >= 64 && k < 71) r = 7'(1 << (k - 64));
    else if (k < 64) begin
      for (int p = 3; p < 128; p++)
        if ((p & (p - 1)) != 0) begin
          if (n == k) r = 7'(p);
          n++;
        end
    end
    return r;
  endfunction

  function automatic logic [63:0] merge(logic [63:0] o, logic [63:0] n, logic [7:0] be);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  task automatic xact(input bit wr, input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 1;
    while (!rsp_valid) begin r_lat++; @(negedge clk); end
    r_data = rsp_rdata; r_single = rsp_single; r_multi = rsp_multi; r_syn = rsp_syn;
    @(negedge clk);
    chk(rsp_valid && !req_ready && rsp_rdata == r_data && rsp_multi == r_multi
        && rsp_single == r_single && rsp_syn == r_syn, "R9 hold", {rsp_valid, req_ready}, 2'b10);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [71:0] m);
    @(negedge clk);
    inj_en = 1'b1; inj_addr = a; inj_mask = m;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 200000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [71:0] saved;
    logic [63:0] exp_d;
    #3;
    chk(!rsp_valid && req_ready && !mem_en, "R11 in reset", {rsp_valid, req_ready, mem_en}, 3'b010);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready && !mem_en, "R11 after reset", {rsp_valid, req_ready, mem_en}, 3'b010);

    // R1 R2 R10: clean full writes and reads
    for (int a = 0; a < 16; a++) begin
      xact(1'b1, AW'(a), pat(a), 8'hFF);
      chk(r_lat == 1, "R10 full write latency", 72'(r_lat), 72'd1);
      chk(mem[a][63:0] == pat(a) && (^mem[a]) == 1'b0, "R1 stored layout", mem[a], {8'h0, pat(a)});
      xact(1'b0, AW'(a), '0, '0);
      chk(r_lat == 2, "R10 read latency", 72'(r_lat), 72'd2);
      chk(r_data == pat(a) && !r_single && !r_multi && r_syn == 0, "R2 clean read",
          {r_single, r_multi, r_data}, {2'b00, pat(a)});
    end

    // R3: every single-bit position, correction on
    corr_en = 1'b1;
    for (int k = 0; k < 72; k++) begin
      xact(1'b1, AW'(k), pat(k), 8'hFF);
      inject(AW'(k), 72'(1) << k);
      xact(1'b0, AW'(k), '0, '0);
      chk(r_data == pat(k), "R3 corrected data", {8'h0, r_data}, {8'h0, pat(k)});
      chk(r_single && !r_multi, "R3 flags", {r_single, r_multi}, 2'b10);
      chk(r_syn == {1'b1, exp_pos(k)}, "R3 syndrome", 72'(r_syn), 72'({1'b1, exp_pos(k)}));
    end

    // R4: two flipped bits, both modes
    for (int k = 0; k < 71; k++) begin
      corr_en = k[0];
      xact(1'b1, AW'(100 + k), pat(k), 8'hFF);
      inject(AW'(100 + k), (72'(1) << k) | (72'(1) << (k == 70 ? 0 : k + 1 + (k % 3))));
      xact(1'b0, AW'(100 + k), '0, '0);
      chk(r_multi && !r_single, "R4 double error", {r_single, r_multi}, 2'b01);
    end

    // R5: detect-only mode passes data through
    corr_en = 1'b0;
    for (int k = 0; k < 72; k++) begin
      xact(1'b1, AW'(k), pat(k + 7), 8'hFF);
      inject(AW'(k), 72'(1) << k);
      xact(1'b0, AW'(k), '0, '0);
      exp_d = pat(k + 7) ^ (k < 64 ? (64'(1) << k) : 64'h0);
      chk(r_data == exp_d && r_single && !r_multi, "R5 raw data",
          {r_single, r_multi, r_data}, {2'b10, exp_d});
    end
    corr_en = 1'b1;

    // R6: partial writes
    foreach (mem[i]) if (i < 9) begin
      logic [7:0] be;
      be = (i == 0) ? 8'h00 : (i == 1) ? 8'h01 : (i == 2) ? 8'h80 : (i == 3) ? 8'h0F :
           (i == 4) ? 8'hF0 : (i == 5) ? 8'h5A : (i == 6) ? 8'hA5 : (i == 7) ? 8'h7F : 8'hFE;
      xact(1'b1, AW'(200 + i), pat(i + 40), 8'hFF);
      xact(1'b1, AW'(200 + i), pat(i + 80), be);
      chk(r_lat == 2 && r_data == 0 && !r_single && !r_multi, "R6 R10 partial response",
          {r_single, r_multi, r_data}, 72'h0);
      exp_d = merge(pat(i + 40), pat(i + 80), be);
      chk(mem[200 + i][63:0] == exp_d && (^mem[200 + i]) == 1'b0, "R6 stored merge",
          mem[200 + i], {8'h0, exp_d});
      xact(1'b0, AW'(200 + i), '0, '0);
      chk(r_data == exp_d && !r_single, "R6 read merge", {8'h0, r_data}, {8'h0, exp_d});
    end

    // R7: partial write over a single-bit error
    xact(1'b1, AW'(220), pat(3), 8'hFF);
    inject(AW'(220), 72'(1) << 12);
    xact(1'b1, AW'(220), pat(9), 8'h03);
    chk(r_single && !r_multi, "R7 response flags", {r_single, r_multi}, 2'b10);
    exp_d = merge(pat(3), pat(9), 8'h03);
    xact(1'b0, AW'(220), '0, '0);
    chk(r_data == exp_d && !r_single && !r_multi, "R7 merged with corrected",
        {r_single, r_multi, r_data}, {2'b00, exp_d});

    // R8: partial write over an uncorrectable error
    xact(1'b1, AW'(221), pat(4), 8'hFF);
    inject(AW'(221), (72'(1) << 2) | (72'(1) << 40));
    @(negedge clk);
    saved = mem[221];
    xact(1'b1, AW'(221), pat(10), 8'hF0);
    chk(r_multi && !r_single, "R8 response flags", {r_single, r_multi}, 2'b01);
    chk(mem[221] == saved, "R8 memory unchanged", mem[221], saved);

    // R1: full write overwrites a corrupted word cleanly
    xact(1'b1, AW'(221), pat(11), 8'hFF);
    xact(1'b0, AW'(221), '0, '0);
    chk(r_data == pat(11) && !r_single && !r_multi, "R1 R2 rewrite clean",
        {r_single, r_multi, r_data}, {2'b00, pat(11)});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule